// File: doc/BRIEF.md
# Bus Mode Detect Controller

This block decides which signalling family is present on a parallel bus and drives the control enables of a differential terminator to match. Two threshold comparators watch a shared sense line and report their results to the block as digital levels. A level under the lower threshold means a single-ended device shares the bus. A level over the upper threshold means a high-voltage differential device is present. A level between the two thresholds means every device on the bus is low-voltage differential. Termination is connected only in that last case.

Any change of class is debounced before it takes effect. The new class has to persist for a programmable number of clock cycles before the committed mode moves. The same delay applies to every transition, and a new qualification may begin on the very cycle after a commit.

Three side inputs override the committed mode. An isolate request disconnects the termination but leaves the filter and the status bit running. A master/slave strap decides whether this terminator drives the sense line. A thermal-shutdown flag turns off the reference, the driver, the status and the filter. When the flag clears, qualification starts again from the present class with a full delay.

Top module: `bus_mode_detect`

## Requirements
- R1: The synchronized comparator pair is classified as follows. below_lo=1 is single-ended, whatever above_hi is, so the contradictory pair 1/1 also counts as single-ended. below_lo=0 with above_hi=1 is high-voltage differential. Both at 0 is low-voltage differential.
- R2: term_isolate is 0 only when the committed mode is low-voltage differential and neither an isolate request nor thermal shutdown is active. Otherwise it is 1.
- R3: With DELAY_CYC=D, a class change held steady at the comparator ports moves lvd_active exactly D+4 rising edges after the first edge that samples it. That count is 2 synchronizer stages, 1 load edge, D count edges and 1 commit edge. A different class held for D+1 cycles or fewer leaves the committed mode unchanged.
- R4: The latency is identical when entering low-voltage differential mode and when leaving it for either single-ended or high-voltage differential.
- R5: A new class applied on the cycle right after a commit is committed with the same D+4 edge latency. No lockout period applies.
- R6: While iso_req=1 (no thermal shutdown), term_isolate=1, ref_en=1 and sense_drv_en=0. The filter keeps qualifying, and lvd_active follows the committed mode with the R3 latency.
- R7: While therm_shdn=1, term_isolate=1, ref_en=0, sense_drv_en=0 and lvd_active=0, and the committed mode does not change.
- R8: sense_drv_en is 1 exactly when master_strap=1, iso_req=0 and therm_shdn=0.
- R9: After reset the committed mode is single-ended: lvd_active=0, term_isolate=1 and ref_en=1, and sense_drv_en follows R8.
- R10: When therm_shdn falls, a class held during the shutdown that differs from the committed mode is committed D+1 rising edges after the first edge with therm_shdn=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_below_lo | input | 1 | Sense level is under the lower threshold |
| cmp_above_hi | input | 1 | Sense level is over the upper threshold |
| iso_req | input | 1 | External request to isolate the termination |
| master_strap | input | 1 | High: this terminator drives the sense line |
| therm_shdn | input | 1 | Thermal shutdown active |
| term_isolate | output | 1 | Disconnect termination from the bus |
| sense_drv_en | output | 1 | Enable for the sense-line driver |
| ref_en | output | 1 | Enable for the reference regulator |
| lvd_active | output | 1 | Committed mode is low-voltage differential |

## Verification
The embedded properties are checked on every cycle. They cover these rules:
- the committed mode may move only after its counter has run out;
- the counter is reloaded whenever the synchronized class departs from the candidate;
- the committed mode is frozen during thermal shutdown;
- termination is never connected unless the status bit is high;
- the sense-line driver never runs without the strap, or during isolation or shutdown.

Only the bench's scenarios can show the exact D+4 edge latency in each direction, the rejection of a pulse one cycle too short, an immediate re-qualification after a commit, status tracking during isolation, and the full-delay restart when shutdown ends.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    typedef enum logic [1:0] {
        MODE_SE  = 2'd0,
        MODE_LVD = 2'd1,
        MODE_HVD = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic below_lo;
        logic above_hi;
    } cmp_s;

    typedef struct packed {
        logic term_isolate;
        logic sense_drv_en;
        logic ref_en;
        logic lvd_active;
    } term_ctl_s;

    // R1: a low reading wins, so the contradictory pair is single-ended
    function automatic bus_mode_e classify(input cmp_s c);
        if (c.below_lo)      return MODE_SE;
        else if (c.above_hi) return MODE_HVD;
        else                 return MODE_LVD;
    endfunction

endpackage

// File: rtl/bmd_sync.sv
module bmd_sync #(
    parameter int unsigned WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/bmd_filter.sv
module bmd_filter
    import bmd_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      therm_i,
    input  bus_mode_e raw_i,
    output bus_mode_e mode_o
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(DELAY_CYC);

    bus_mode_e     cand_q;
    bus_mode_e     commit_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q   <= MODE_SE;
            commit_q <= MODE_SE;
            cnt_q    <= FULL;
        end else if (therm_i) begin
            // receiver disabled: track raw class, keep a full delay armed
            cand_q <= raw_i;
            cnt_q  <= FULL;
        end else if (raw_i != cand_q) begin
            cand_q <= raw_i;
            cnt_q  <= FULL;
        end else if (cand_q != commit_q) begin
            if (cnt_q == '0) commit_q <= cand_q;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign mode_o = commit_q;

    AST_COMMIT_AFTER_COUNT: assert property (@(posedge clk) disable iff (rst)
        (commit_q != $past(commit_q)) |-> ($past(cnt_q) == '0 && $past(cand_q) == commit_q)); // R3
    AST_RELOAD_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!therm_i && raw_i != cand_q) |=> (cnt_q == FULL && cand_q == $past(raw_i))); // R5
    AST_THERM_FREEZE: assert property (@(posedge clk) disable iff (rst)
        therm_i |=> (commit_q == $past(commit_q) && cnt_q == FULL)); // R7
endmodule

// File: rtl/bmd_outctl.sv
module bmd_outctl
    import bmd_pkg::*;
(
    input  bus_mode_e mode_i,
    input  logic      iso_i,
    input  logic      strap_i,
    input  logic      therm_i,
    output term_ctl_s ctl_o
);
    logic lvd_mode;

    always_comb begin
        lvd_mode           = (mode_i == MODE_LVD);
        ctl_o.lvd_active   = lvd_mode && !therm_i;
        ctl_o.term_isolate = !lvd_mode || iso_i || therm_i;
        ctl_o.ref_en       = !therm_i;
        ctl_o.sense_drv_en = strap_i && !iso_i && !therm_i;
    end
endmodule

// File: rtl/bus_mode_detect.sv
module bus_mode_detect
    import bmd_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_below_lo,
    input  logic cmp_above_hi,
    input  logic iso_req,
    input  logic master_strap,
    input  logic therm_shdn,
    output logic term_isolate,
    output logic sense_drv_en,
    output logic ref_en,
    output logic lvd_active
);
    logic [1:0] cmp_sync;
    cmp_s       cmp_view;
    bus_mode_e  raw_mode;
    bus_mode_e  committed;
    term_ctl_s  ctl;

    bmd_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cmp_below_lo, cmp_above_hi}),
        .q_o (cmp_sync)
    );

    assign cmp_view = cmp_s'(cmp_sync);
    assign raw_mode = classify(cmp_view);

    bmd_filter #(.DELAY_CYC(DELAY_CYC)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .therm_i (therm_shdn),
        .raw_i   (raw_mode),
        .mode_o  (committed)
    );

    bmd_outctl u_outctl (
        .mode_i  (committed),
        .iso_i   (iso_req),
        .strap_i (master_strap),
        .therm_i (therm_shdn),
        .ctl_o   (ctl)
    );

    assign term_isolate = ctl.term_isolate;
    assign sense_drv_en = ctl.sense_drv_en;
    assign ref_en       = ctl.ref_en;
    assign lvd_active   = ctl.lvd_active;

    AST_TERM_ONLY_LVD: assert property (@(posedge clk) disable iff (rst)
        !term_isolate |-> lvd_active); // R2
    AST_DRV_NEEDS_STRAP: assert property (@(posedge clk) disable iff (rst)
        sense_drv_en |-> (master_strap && !iso_req && !therm_shdn)); // R8
    AST_THERM_SHUTS_ALL: assert property (@(posedge clk) disable iff (rst)
        therm_shdn |-> (!ref_en && !lvd_active && !sense_drv_en && term_isolate)); // R7
    AST_ISO_KEEPS_REF: assert property (@(posedge clk) disable iff (rst)
        (iso_req && !therm_shdn) |-> (ref_en && term_isolate)); // R6
endmodule

// File: tb/bus_mode_detect_tb.sv
module bus_mode_detect_tb;
    localparam int unsigned D   = 16;
    localparam int unsigned LAT = D + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic below_lo = 1'b1, above_hi = 1'b0;
    logic iso = 1'b0, strap = 1'b1, therm = 1'b0;
    logic term_isolate, sense_drv_en, ref_en, lvd_active;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    bus_mode_detect #(.DELAY_CYC(D)) u_dut (
        .clk(clk), .rst(rst),
        .cmp_below_lo(below_lo), .cmp_above_hi(above_hi),
        .iso_req(iso), .master_strap(strap), .therm_shdn(therm),
        .term_isolate(term_isolate), .sense_drv_en(sense_drv_en),
        .ref_en(ref_en), .lvd_active(lvd_active)
    );

    // vector: {below_lo, above_hi, iso, strap, exp lvd, exp term_iso, exp drv, exp ref}
    localparam logic [7:0] VEC [8] = '{
        8'b0001_1011, 8'b0000_1001, 8'b1001_0111, 8'b0101_0111,
        8'b1101_0111, 8'b0011_1101, 8'b0110_0101, 8'b0001_1011
    };

    function automatic logic [3:0] outs();
        return {lvd_active, term_isolate, sense_drv_en, ref_en};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cls(input logic b, input logic a);
        below_lo = b;
        above_hi = a;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(0);
        chk("R9 reset state", outs(), 4'b0111);

        // table walk, steady-state results (R1, R2, R6, R8)
        foreach (VEC[i]) begin
            set_cls(VEC[i][7], VEC[i][6]);
            iso   = VEC[i][5];
            strap = VEC[i][4];
            step(LAT + 2);
            chk($sformatf("R1/R2/R8 vector %0d", i), outs(), VEC[i][3:0]);
        end
        iso = 1'b0; strap = 1'b1;

        // leave LVD for SE: exact latency
        set_cls(1'b1, 1'b0);
        step(LAT - 1);
        chk("R4 leave before latency", {3'b0, lvd_active}, 4'b0001);
        step(1);
        chk("R4 leave at latency", {3'b0, lvd_active}, 4'b0000);

        // immediately re-enter LVD
        set_cls(1'b0, 1'b0);
        step(LAT - 1);
        chk("R5 re-enter before latency", {3'b0, lvd_active}, 4'b0000);
        step(1);
        chk("R3 enter at latency", {3'b0, lvd_active}, 4'b0001);

        // leave LVD for HVD
        set_cls(1'b0, 1'b1);
        step(LAT - 1);
        chk("R4 HVD before latency", {3'b0, lvd_active}, 4'b0001);
        step(1);
        chk("R4 HVD at latency", {3'b0, lvd_active}, 4'b0000);

        // glitch of D+1 cycles is filtered
        set_cls(1'b0, 1'b0);
        step(D + 1);
        set_cls(1'b0, 1'b1);
        step(LAT + 4);
        chk("R3 short pulse filtered", {3'b0, lvd_active}, 4'b0000);

        // isolate: filter keeps qualifying
        iso = 1'b1;
        set_cls(1'b0, 1'b0);
        step(LAT - 1);
        chk("R6 iso before latency", outs(), 4'b0101);
        step(1);
        chk("R6 iso status tracks", outs(), 4'b1101);
        iso = 1'b0;
        step(0);
        chk("R2 iso released", outs(), 4'b1011);

        // thermal shutdown and restart
        set_cls(1'b1, 1'b0);
        step(LAT + 2);
        chk("R9 back to SE", outs(), 4'b0111);
        therm = 1'b1;
        set_cls(1'b0, 1'b0);
        step(LAT + 6);
        chk("R7 thermal forces outputs", outs(), 4'b0100);
        therm = 1'b0;
        step(D);
        chk("R10 restart before full delay", outs(), 4'b0111);
        step(1);
        chk("R10 restart commits", outs(), 4'b1011);

        // committed mode held across shutdown
        therm = 1'b1;
        set_cls(1'b1, 1'b0);
        step(LAT + 6);
        therm = 1'b0;
        step(0);
        chk("R7 mode held through shutdown", outs(), 4'b1011);
        step(D + 1);
        chk("R10 SE qualified after release", outs(), 4'b0111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule